// File: doc/BRIEF.md
# Nonvolatile Programming Command Sequencer

This block sits between a host controller and a serial frame engine that talks to a nonvolatile memory's programming port. The host requests one of five high-level operations with a single one-hot pulse. The block breaks each operation into an ordered series of frames. Each frame pairs a data byte with an instruction byte. The block hands the frames to the engine one at a time and waits for each to complete. It collects the bytes the engine returns and reports the end of the operation.

The memory keeps the last loaded command and the last high address byte between operations. The sequencer mirrors that state in a small cache and drops frames that would only reload the same values. A long run of reads in one 256-word window then costs the data frames alone. Chip erase, no-operation and a mode-entry pulse each clear the cache. For erase and fuse write, the block flags the final frame so that the engine polls the ready line before it reports completion.

Top module: `nvprog_sequencer`

## Requirements
- R1: After reset, frmValid, opAck, opErr, opDone and rdValid are all low.
- R2: A request on opReq[0] (chip erase) issues three frames as data/instruction pairs: 0x80/0x4C, then 0x00/0x64, then 0x00/0x6C. Only the last of the three has frmPoll high.
- R3: A request on opReq[4] (no-operation) issues exactly one frame, 0x00/0x4C.
- R4: A request on opReq[1] (read program word at opAddr) issues these frames in order: 0x02/0x4C (command), opAddr[7:0]/0x0C, opAddr[15:8]/0x1C (high address), 0x00/0x68, 0x00/0x6C, 0x00/0x78, 0x00/0x7C. The byte returned for 0x6C is the low byte and the byte returned for 0x7C is the high byte. In the cycle opDone is high, rdValid is high and rdData = {high, low}.
- R5: A request on opReq[2] (fuse low write of opData) issues 0x40/0x4C (command), opData/0x2C, 0x00/0x64 and 0x00/0x6C. Only the last frame has frmPoll high.
- R6: A request on opReq[3] (fuse low read) issues 0x04/0x4C (command), 0x00/0x68 and 0x00/0x6C. In the cycle opDone is high, rdValid is high and rdData = {0x00, byte returned for 0x6C}.
- R7: The command frame (instruction 0x4C) of a read word, fuse write or fuse read is left out when the previous completed operation loaded the same command and the cache has not been cleared since.
- R8: The high address frame (0x1C) of a read word is left out when the cache holds a valid high address equal to opAddr[15:8].
- R9: After chip erase, after no-operation and after a modeEnter pulse, both the command and the high address are resent by the next operation that uses them.
- R10: A non-zero opReq that is not one-hot, or any request while an operation is in progress, raises opErr for one cycle. No opAck follows and no frame is issued for it.
- R11: opAck is high for one cycle, one cycle after an accepted request. opDone is high for one cycle, one cycle after the last frame's frmDone.
- R12: frmPoll is high only on the 0x6C frame of chip erase and of fuse write.
- R13: An offered frame keeps frmValid, frmData, frmInstr and frmPoll unchanged until frmReady accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| modeEnter | input | 1 | Pulse: memory entered programming mode, clear the cache |
| opReq | input | 5 | One-hot request: [0] erase, [1] read word, [2] fuse write, [3] fuse read, [4] no-op |
| opAddr | input | 16 | Word address for read word, latched on accept |
| opData | input | 8 | Fuse byte for fuse write, latched on accept |
| opAck | output | 1 | Request accepted |
| opErr | output | 1 | Request rejected |
| opDone | output | 1 | Operation complete |
| rdData | output | 16 | Read result {high, low} |
| rdValid | output | 1 | rdData valid, with opDone on reads |
| frmValid | output | 1 | A frame is offered |
| frmReady | input | 1 | Engine accepts the offered frame |
| frmData | output | 8 | Frame data byte |
| frmInstr | output | 8 | Frame instruction byte |
| frmPoll | output | 1 | Engine must wait for ready after this frame |
| frmDone | input | 1 | Engine finished the accepted frame |
| frmRx | input | 8 | Byte returned by the finished frame |

## Verification
On every cycle the assertions check that offered frames hold still until accepted and that polling is requested only on the 0x6C frame. They also check that no command or high-address frame is ever issued that repeats a valid cached value, that a mode-entry pulse clears the cache, and that the acknowledge, done and error pulses keep their one-cycle, mutually exclusive shape. Only the bench scenarios can show the exact frame orders, which frames are skipped across mixed operation sequences, and the returned data assembly. The bench models the memory as a device that honours the retained command and address, so a wrongly skipped frame shows up as wrong data.

// File: rtl/nvprog_seq_pkg.sv
package nvprog_seq_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 2 * BYTE_W;
  localparam int NUM_OPS = 5;
  localparam int STEP_W  = 3;

  typedef enum logic [2:0] {OP_ERASE, OP_RDWORD, OP_WRFUSE, OP_RDFUSE, OP_NOP} op_e;
  typedef enum logic [1:0] {DS_CONST, DS_ADDRLO, DS_ADDRHI, DS_FUSE} dsel_e;
  typedef enum logic [1:0] {SK_NONE, SK_CMD, SK_HI} skip_e;

  typedef struct packed {
    logic [BYTE_W-1:0] instr;
    logic [BYTE_W-1:0] konst;
    dsel_e             dsel;
    skip_e             skip;
    logic              poll;
    logic              capLo;
    logic              capHi;
    logic              last;
  } step_t;

  typedef struct packed {
    logic              latchReq;
    logic              capLo;
    logic              capHi;
    logic              setCmd;
    logic              setHi;
    logic              clrCache;
    logic [BYTE_W-1:0] cmdByte;
    dsel_e             dsel;
    logic [BYTE_W-1:0] konst;
  } strobe_t;
endpackage

// File: rtl/nvprog_seq_ctrl.sv
module nvprog_seq_ctrl
  import nvprog_seq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_OPS-1:0]     opReq,
  input  logic                   frmReady,
  input  logic                   frmDone,
  input  logic                   cmdValid,
  input  logic [BYTE_W-1:0]      cmdCache,
  input  logic                   hiHit,
  output logic                   opAck,
  output logic                   opErr,
  output logic                   opDone,
  output logic                   rdValid,
  output logic                   frmValid,
  output logic [BYTE_W-1:0]      frmInstr,
  output logic                   frmPoll,
  output strobe_t                stb
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_e;

  state_e            state;
  op_e               op;
  logic [STEP_W-1:0] step;
  step_t             si;
  step_t             si0;
  logic              reqOk;
  logic              skipNow;
  op_e               reqOp;

  function automatic step_t mk(input logic [7:0] ins, input logic [7:0] k, input dsel_e ds,
                               input skip_e sk, input logic pl, input logic cl,
                               input logic ch, input logic ls);
    step_t s;
    s.instr = ins; s.konst = k; s.dsel = ds; s.skip = sk;
    s.poll = pl; s.capLo = cl; s.capHi = ch; s.last = ls;
    return s;
  endfunction

  function automatic step_t lookup(input op_e o, input logic [STEP_W-1:0] i);
    step_t s;
    s = mk(8'h4C, 8'h00, DS_CONST, SK_NONE, 1'b0, 1'b0, 1'b0, 1'b1);
    case (o)
      OP_ERASE: case (i)
        3'd0:    s = mk(8'h4C, 8'h80, DS_CONST, SK_NONE, 1'b0, 1'b0, 1'b0, 1'b0);
        3'd1:    s = mk(8'h64, 8'h00, DS_CONST, SK_NONE, 1'b0, 1'b0, 1'b0, 1'b0);
        default: s = mk(8'h6C, 8'h00, DS_CONST, SK_NONE, 1'b1, 1'b0, 1'b0, 1'b1);
      endcase
      OP_RDWORD: case (i)
        3'd0:    s = mk(8'h4C, 8'h02, DS_CONST,  SK_CMD,  1'b0, 1'b0, 1'b0, 1'b0);
        3'd1:    s = mk(8'h0C, 8'h00, DS_ADDRLO, SK_NONE, 1'b0, 1'b0, 1'b0, 1'b0);
        3'd2:    s = mk(8'h1C, 8'h00, DS_ADDRHI, SK_HI,   1'b0, 1'b0, 1'b0, 1'b0);
        3'd3:    s = mk(8'h68, 8'h00, DS_CONST,  SK_NONE, 1'b0, 1'b0, 1'b0, 1'b0);
        3'd4:    s = mk(8'h6C, 8'h00, DS_CONST,  SK_NONE, 1'b0, 1'b1, 1'b0, 1'b0);
        3'd5:    s = mk(8'h78, 8'h00, DS_CONST,  SK_NONE, 1'b0, 1'b0, 1'b0, 1'b0);
        default: s = mk(8'h7C, 8'h00, DS_CONST,  SK_NONE, 1'b0, 1'b0, 1'b1, 1'b1);
      endcase
      OP_WRFUSE: case (i)
        3'd0:    s = mk(8'h4C, 8'h40, DS_CONST, SK_CMD,  1'b0, 1'b0, 1'b0, 1'b0);
        3'd1:    s = mk(8'h2C, 8'h00, DS_FUSE,  SK_NONE, 1'b0, 1'b0, 1'b0, 1'b0);
        3'd2:    s = mk(8'h64, 8'h00, DS_CONST, SK_NONE, 1'b0, 1'b0, 1'b0, 1'b0);
        default: s = mk(8'h6C, 8'h00, DS_CONST, SK_NONE, 1'b1, 1'b0, 1'b0, 1'b1);
      endcase
      OP_RDFUSE: case (i)
        3'd0:    s = mk(8'h4C, 8'h04, DS_CONST, SK_CMD,  1'b0, 1'b0, 1'b0, 1'b0);
        3'd1:    s = mk(8'h68, 8'h00, DS_CONST, SK_NONE, 1'b0, 1'b0, 1'b0, 1'b0);
        default: s = mk(8'h6C, 8'h00, DS_CONST, SK_NONE, 1'b0, 1'b1, 1'b0, 1'b1);
      endcase
      default: s = mk(8'h4C, 8'h00, DS_CONST, SK_NONE, 1'b0, 1'b0, 1'b0, 1'b1);
    endcase
    return s;
  endfunction

  always_comb begin
    reqOk = (opReq != '0) && ((opReq & (opReq - 1'b1)) == '0);
    reqOp = OP_NOP;
    if (opReq[0]) reqOp = OP_ERASE;
    else if (opReq[1]) reqOp = OP_RDWORD;
    else if (opReq[2]) reqOp = OP_WRFUSE;
    else if (opReq[3]) reqOp = OP_RDFUSE;
  end

  always_comb begin
    si  = lookup(op, step);
    si0 = lookup(op, '0);
    skipNow = ((si.skip == SK_CMD) && cmdValid && (cmdCache == si.konst)) ||
              ((si.skip == SK_HI) && hiHit);
    frmValid = (state == S_ISSUE) && !skipNow;
    frmInstr = si.instr;
    frmPoll  = si.poll;
    opDone   = (state == S_DONE);
    rdValid  = (state == S_DONE) && ((op == OP_RDWORD) || (op == OP_RDFUSE));

    stb          = '0;
    stb.dsel     = si.dsel;
    stb.konst    = si.konst;
    stb.cmdByte  = si0.konst;
    stb.latchReq = (state == S_IDLE) && reqOk;
    stb.capLo    = (state == S_WAIT) && frmDone && si.capLo;
    stb.capHi    = (state == S_WAIT) && frmDone && si.capHi;
    if (state == S_DONE) begin
      stb.clrCache = (op == OP_ERASE) || (op == OP_NOP);
      stb.setCmd   = (op == OP_RDWORD) || (op == OP_WRFUSE) || (op == OP_RDFUSE);
      stb.setHi    = (op == OP_RDWORD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      op    <= OP_NOP;
      step  <= '0;
      opAck <= 1'b0;
      opErr <= 1'b0;
    end else begin
      opAck <= 1'b0;
      opErr <= (opReq != '0) && ((state != S_IDLE) || !reqOk);
      case (state)
        S_IDLE: if (reqOk) begin
          op    <= reqOp;
          step  <= '0;
          state <= S_ISSUE;
          opAck <= 1'b1;
        end
        S_ISSUE: begin
          if (skipNow) begin
            if (si.last) state <= S_DONE;
            else step <= step + 1'b1;
          end else if (frmReady) begin
            state <= S_WAIT;
          end
        end
        S_WAIT: if (frmDone) begin
          if (si.last) state <= S_DONE;
          else begin
            step  <= step + 1'b1;
            state <= S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (frmValid && !frmReady) |=> (frmValid && $stable(frmInstr) && $stable(frmPoll)));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    opDone |=> !opDone);
  p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    opAck |=> !opAck);
  p_err_no_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    opErr |-> !opAck);
endmodule

// File: rtl/nvprog_seq_dp.sv
module nvprog_seq_dp
  import nvprog_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeEnter,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [BYTE_W-1:0] opData,
  input  logic [BYTE_W-1:0] frmRx,
  output logic [BYTE_W-1:0] frmData,
  output logic [ADDR_W-1:0] rdData,
  output logic              cmdValid,
  output logic [BYTE_W-1:0] cmdCache,
  output logic              hiHit
);
  logic [ADDR_W-1:0] addrQ;
  logic [BYTE_W-1:0] fuseQ;
  logic [BYTE_W-1:0] rdLo;
  logic [BYTE_W-1:0] rdHi;
  logic [BYTE_W-1:0] hiCache;
  logic              hiValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ <= '0;
      fuseQ <= '0;
      rdLo  <= '0;
      rdHi  <= '0;
    end else begin
      if (stb.latchReq) begin
        addrQ <= opAddr;
        fuseQ <= opData;
        rdLo  <= '0;
        rdHi  <= '0;
      end
      if (stb.capLo) rdLo <= frmRx;
      if (stb.capHi) rdHi <= frmRx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdValid <= 1'b0;
      cmdCache <= '0;
      hiValid  <= 1'b0;
      hiCache  <= '0;
    end else if (modeEnter || stb.clrCache) begin
      cmdValid <= 1'b0;
      hiValid  <= 1'b0;
    end else begin
      if (stb.setCmd) begin
        cmdValid <= 1'b1;
        cmdCache <= stb.cmdByte;
      end
      if (stb.setHi) begin
        hiValid <= 1'b1;
        hiCache <= addrQ[ADDR_W-1:BYTE_W];
      end
    end
  end

  always_comb begin
    hiHit  = hiValid && (hiCache == addrQ[ADDR_W-1:BYTE_W]);
    rdData = {rdHi, rdLo};
    case (stb.dsel)
      DS_ADDRLO: frmData = addrQ[BYTE_W-1:0];
      DS_ADDRHI: frmData = addrQ[ADDR_W-1:BYTE_W];
      DS_FUSE:   frmData = fuseQ;
      default:   frmData = stb.konst;
    endcase
  end

  p_mode_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(modeEnter) |-> (!cmdValid && !hiHit));
endmodule

// File: rtl/nvprog_sequencer.sv
module nvprog_sequencer
  import nvprog_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  modeEnter,
  input  logic [NUM_OPS-1:0]    opReq,
  input  logic [ADDR_W-1:0]     opAddr,
  input  logic [BYTE_W-1:0]     opData,
  output logic                  opAck,
  output logic                  opErr,
  output logic                  opDone,
  output logic [ADDR_W-1:0]     rdData,
  output logic                  rdValid,
  output logic                  frmValid,
  input  logic                  frmReady,
  output logic [BYTE_W-1:0]     frmData,
  output logic [BYTE_W-1:0]     frmInstr,
  output logic                  frmPoll,
  input  logic                  frmDone,
  input  logic [BYTE_W-1:0]     frmRx
);
  strobe_t           stb;
  logic              cmdValid;
  logic [BYTE_W-1:0] cmdCache;
  logic              hiHit;

  nvprog_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .opReq(opReq), .frmReady(frmReady), .frmDone(frmDone),
    .cmdValid(cmdValid), .cmdCache(cmdCache), .hiHit(hiHit),
    .opAck(opAck), .opErr(opErr), .opDone(opDone), .rdValid(rdValid),
    .frmValid(frmValid), .frmInstr(frmInstr), .frmPoll(frmPoll), .stb(stb)
  );

  nvprog_seq_dp u_dp (
    .clk(clk), .rst_n(rst_n), .modeEnter(modeEnter), .stb(stb),
    .opAddr(opAddr), .opData(opData), .frmRx(frmRx),
    .frmData(frmData), .rdData(rdData), .cmdValid(cmdValid),
    .cmdCache(cmdCache), .hiHit(hiHit)
  );

  p_cmd_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frmValid && frmInstr == 8'h4C && cmdValid) |-> (frmData != cmdCache));
  p_hi_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frmValid && frmInstr == 8'h1C) |-> !hiHit);
  p_poll_last_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (frmValid && frmPoll) |-> (frmInstr == 8'h6C));
endmodule

// File: tb/nvprog_sequencer_bench.sv
module nvprog_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        modeEnter = 1'b0;
  logic [4:0]  opReq = '0;
  logic [15:0] opAddr = '0;
  logic [7:0]  opData = '0;
  logic        opAck, opErr, opDone, rdValid, frmValid, frmPoll;
  logic [15:0] rdData;
  logic [7:0]  frmData, frmInstr;
  logic        frmReady = 1'b0;
  logic        frmDone = 1'b0;
  logic [7:0]  frmRx = '0;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  nvprog_sequencer u_nvprog_sequencer (
    .clk(clk), .rst_n(rst_n), .modeEnter(modeEnter), .opReq(opReq), .opAddr(opAddr),
    .opData(opData), .opAck(opAck), .opErr(opErr), .opDone(opDone), .rdData(rdData),
    .rdValid(rdValid), .frmValid(frmValid), .frmReady(frmReady), .frmData(frmData),
    .frmInstr(frmInstr), .frmPoll(frmPoll), .frmDone(frmDone), .frmRx(frmRx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] memWord(input logic [15:0] a);
    logic [31:0] p;
    p = a * 32'h9E37;
    return p[15:0] ^ 16'h5A51;
  endfunction

  // frame log and device model
  logic [7:0] logD [0:15];
  logic [7:0] logI [0:15];
  logic       logP [0:15];
  int         logN = 0;
  int         frmCount = 0;
  logic [7:0] devCmd = 8'h00, devLo = 8'h00, devHi = 8'h00, devLatch = 8'h00, devFuse = 8'hFF;

  initial begin
    logic [7:0] d0, i0, rx;
    logic       p0;
    forever begin
      @(negedge clk);
      frmDone  = 1'b0;
      frmReady = 1'b0;
      if (rst_n && frmValid) begin
        d0 = frmData; i0 = frmInstr; p0 = frmPoll;
        repeat (frmCount % 3) @(negedge clk);
        chk(frmValid && frmData == d0 && frmInstr == i0 && frmPoll == p0,
            "R13 frame held until accepted", {frmData, frmInstr}, {d0, i0});
        frmReady = 1'b1;
        if (logN < 16) begin
          logD[logN] = d0; logI[logN] = i0; logP[logN] = p0;
        end
        logN++;
        frmCount++;
        rx = 8'h00;
        case (i0)
          8'h4C: devCmd = d0;
          8'h0C: devLo = d0;
          8'h1C: devHi = d0;
          8'h2C: devLatch = d0;
          8'h6C: begin
            if (devCmd == 8'h40) devFuse = devLatch;
            if (devCmd == 8'h02) rx = memWord({devHi, devLo})[7:0];
            if (devCmd == 8'h04) rx = devFuse;
          end
          8'h7C: if (devCmd == 8'h02) rx = memWord({devHi, devLo})[15:8];
          default: ;
        endcase
        @(negedge clk);
        frmReady = 1'b0;
        repeat (p0 ? 6 : 1) @(negedge clk);
        frmRx   = rx;
        frmDone = 1'b1;
      end
    end
  end

  // bench-side cache model and expected frames
  logic       mCmdV = 1'b0, mHiV = 1'b0;
  logic [7:0] mCmd = 8'h00, mHi = 8'h00, mFuse = 8'hFF;
  logic [7:0] expD [0:15];
  logic [7:0] expI [0:15];
  logic       expP [0:15];
  int         expN = 0;

  task automatic push(input logic [7:0] d, input logic [7:0] i, input logic p);
    expD[expN] = d; expI[expN] = i; expP[expN] = p; expN++;
  endtask

  task automatic runOp(input int opIdx, input logic [15:0] a, input logic [7:0] d,
                       input string req, output logic [15:0] res, output logic rv);
    int t;
    bit ok;
    int bad;
    expN = 0;
    case (opIdx)
      0: begin push(8'h80, 8'h4C, 0); push(8'h00, 8'h64, 0); push(8'h00, 8'h6C, 1);
               mCmdV = 0; mHiV = 0; end
      1: begin
           if (!(mCmdV && mCmd == 8'h02)) push(8'h02, 8'h4C, 0);
           push(a[7:0], 8'h0C, 0);
           if (!(mHiV && mHi == a[15:8])) push(a[15:8], 8'h1C, 0);
           push(8'h00, 8'h68, 0); push(8'h00, 8'h6C, 0);
           push(8'h00, 8'h78, 0); push(8'h00, 8'h7C, 0);
           mCmdV = 1; mCmd = 8'h02; mHiV = 1; mHi = a[15:8];
         end
      2: begin
           if (!(mCmdV && mCmd == 8'h40)) push(8'h40, 8'h4C, 0);
           push(d, 8'h2C, 0); push(8'h00, 8'h64, 0); push(8'h00, 8'h6C, 1);
           mCmdV = 1; mCmd = 8'h40; mFuse = d;
         end
      3: begin
           if (!(mCmdV && mCmd == 8'h04)) push(8'h04, 8'h4C, 0);
           push(8'h00, 8'h68, 0); push(8'h00, 8'h6C, 0);
           mCmdV = 1; mCmd = 8'h04;
         end
      default: begin push(8'h00, 8'h4C, 0); mCmdV = 0; mHiV = 0; end
    endcase
    @(negedge clk);
    logN = 0;
    opReq = 5'(1 << opIdx); opAddr = a; opData = d;
    @(negedge clk);
    opReq = '0;
    chk(opAck === 1'b1 && opErr === 1'b0, "R11 ack after request", opAck, 1);
    t = 0;
    while (opDone !== 1'b1 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 2000, "R11 operation completes", t, 0);
    res = rdData;
    rv  = rdValid;
    ok  = (logN == expN);
    bad = -1;
    for (int k = 0; k < expN && k < 16; k++)
      if (bad < 0 && (logD[k] != expD[k] || logI[k] != expI[k] || logP[k] != expP[k])) bad = k;
    if (bad >= 0) ok = 0;
    if (bad >= 0)
      chk(ok, req, {logD[bad], logI[bad], 7'h0, logP[bad]}, {expD[bad], expI[bad], 7'h0, expP[bad]});
    else
      chk(ok, req, logN, expN);
    @(negedge clk);
    chk(opDone === 1'b0, "R11 done is one cycle", opDone, 0);
  endtask

  logic [15:0] res;
  logic        rv;

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(frmValid === 0 && opAck === 0 && opErr === 0 && opDone === 0 && rdValid === 0,
        "R1 outputs idle in reset", {frmValid, opAck, opErr, opDone, rdValid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(frmValid === 0 && opAck === 0 && opErr === 0 && opDone === 0 && rdValid === 0,
        "R1 outputs idle after reset", {frmValid, opAck, opErr, opDone, rdValid}, 0);

    // R3 no-op
    runOp(4, 16'h0, 8'h0, "R3 no-op frame", res, rv);

    // R4 R7 R8 read word sweep, window changes every 8 addresses
    for (int i = 0; i < 48; i++) begin
      logic [15:0] a;
      a = 16'(((i >> 3) * 16'h0500) | ((i * 29) & 8'hFF));
      if (i == 20) a = 16'h0A00 | 16'h00FF;
      runOp(1, a, 8'h00, "R4 R7 R8 read word frames", res, rv);
      chk(rv === 1'b1 && res == memWord(a), "R4 read word result", res, memWord(a));
    end

    // R5 R6 R7 fuse sweep over every byte value
    for (int v = 0; v < 256; v++) begin
      runOp(2, 16'h0, 8'(v), "R5 R12 fuse write frames", res, rv);
      runOp(3, 16'h0, 8'h00, "R6 R7 fuse read frames", res, rv);
      chk(rv === 1'b1 && res == {8'h00, 8'(v)}, "R6 fuse read result", res, {8'h00, 8'(v)});
    end

    // R2 R9 erase clears cache
    runOp(1, 16'h1234, 8'h00, "R4 read word frames", res, rv);
    runOp(1, 16'h1235, 8'h00, "R7 R8 repeated read skips", res, rv);
    runOp(0, 16'h0, 8'h00, "R2 R12 erase frames", res, rv);
    chk(rv === 1'b0, "R2 erase gives no read strobe", rv, 0);
    runOp(1, 16'h1236, 8'h00, "R9 command and high resent after erase", res, rv);
    chk(res == memWord(16'h1236), "R9 read after erase", res, memWord(16'h1236));

    // R9 mode entry clears cache
    @(negedge clk); modeEnter = 1'b1;
    @(negedge clk); modeEnter = 1'b0;
    mCmdV = 0; mHiV = 0;
    runOp(1, 16'h1237, 8'h00, "R9 command and high resent after mode entry", res, rv);

    // R9 no-op clears cache
    runOp(4, 16'h0, 8'h00, "R3 no-op frame", res, rv);
    runOp(1, 16'h1238, 8'h00, "R9 command and high resent after no-op", res, rv);
    chk(res == memWord(16'h1238), "R9 read after no-op", res, memWord(16'h1238));

    // R10 request while busy
    @(negedge clk);
    opReq = 5'b01000;
    @(negedge clk);
    opReq = 5'b00010;
    chk(opAck === 1'b1, "R11 ack for fuse read", opAck, 1);
    @(negedge clk);
    opReq = '0;
    chk(opErr === 1'b1 && opAck === 1'b0, "R10 busy request rejected", {opErr, opAck}, 2);
    @(negedge clk);
    chk(opErr === 1'b0, "R10 error is one cycle", opErr, 0);
    while (opDone !== 1'b1) @(negedge clk);
    chk(rdData == {8'h00, mFuse}, "R10 running read unaffected", rdData, {8'h00, mFuse});
    mCmdV = 1; mCmd = 8'h04;
    repeat (3) @(negedge clk);
    chk(frmValid === 1'b0, "R10 busy request not queued", frmValid, 0);

    // R10 multi-hot at idle
    opReq = 5'b00110;
    @(negedge clk);
    opReq = '0;
    chk(opErr === 1'b1 && opAck === 1'b0, "R10 multi-hot rejected", {opErr, opAck}, 2);
    repeat (4) begin
      @(negedge clk);
      chk(frmValid === 1'b0 && opAck === 1'b0, "R10 multi-hot issues nothing", frmValid, 0);
    end

    // cache intact after rejection: fuse read skips command
    runOp(3, 16'h0, 8'h00, "R7 cache kept after rejected request", res, rv);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule